// File: doc/BRIEF.md
# SDRAM Host Bus Adapter

This block connects a simple synchronous host bus, which behaves like a static RAM port, to an SDRAM command sequencer. The host starts an access by driving select low together with an active-low read or write strobe, a 23-bit byte address, a 2-bit size code and 32-bit write data. The adapter splits the byte address into bank, row, column and byte lane. It works out which byte lanes to mask, realigns sub-word data, and raises exactly one request towards the sequencer. An active-low wait line holds the host until the sequencer acknowledges. Each access moves one transfer; there are no bursts.

A write made while the mode-set input is low does not reach memory. Its low 11 data bits go to the sequencer as a new mode-register word. Read data is caught in a holding register when the read acknowledge arrives. The host sees it in the cycle that wait is released. While the sequencer reports a refresh, the adapter keeps wait low and starts no new request.

The controller is a five-state machine:

- `ST_IDLE` goes to `ST_RD_WAIT`, `ST_WR_WAIT` or `ST_CFG_WAIT` when a read, write or mode-set write starts.
- Each wait state goes to `ST_DONE` on its own acknowledge.
- `ST_DONE` always returns to `ST_IDLE` on the next cycle.

Top module: `sdram_host_adapter`

## Requirements
- R1: While an access is presented, `seq_bank` = addr[22:21], `seq_row` = addr[20:10], `seq_col` = addr[9:2] and the byte lane is addr[1:0].
- R2: `seq_lane_mask` bit i high blocks lane i. Size codes:
  - Size 1 (byte) unmasks only lane addr[1:0].
  - Size 2 (half-word) unmasks lanes 0 and 1 when addr[1]=0, and lanes 2 and 3 when addr[1]=1.
  - Size 0 (word) and the spare code 3 unmask all four lanes.
- R3: With low-order alignment on (the default), write data reaches the sequencer aligned to the lanes:
  - A byte write replicates host data[7:0] into all four lanes.
  - A half-word write replicates data[15:0] into both halves.
  - A word write passes data unchanged.
- R4: Read data is captured on the read acknowledge and shown on `host_rdata` from the cycle wait is released:
  - A byte read yields the addressed lane in bits [7:0] with zeros above.
  - A half-word read yields the addressed half in bits [15:0] with zeros above.
  - A word read is unchanged.
  - `host_rdata` does not change at any other time.
- R5: `host_wait_n` is low in the cycle an access is first presented and stays low until the acknowledge edge. It is high in the cycle after that edge (`ST_DONE`).
- R6: A read (rd low, wr high) raises `seq_rd_req`. A write with mode-set high raises `seq_wr_req`. Either request starts the cycle after the access is presented, holds until its acknowledge, and at most one request is high at a time.
- R7: A write with `host_modeset_n` low raises `seq_cfg_req` instead of `seq_wr_req`, with `seq_cfg_word` = write data[10:0].
- R8: While `seq_refresh` is high and no access is in progress, wait is low and no request is raised. A pending access begins the cycle after refresh ends.
- R9: With select high, the strobes are ignored: no request is raised and wait stays high.
- R10: After reset no request is high, wait is high and `host_rdata` is zero.
- R11: If both strobes are low, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_modeset_n | input | 1 | Mode-register write qualifier, active low |
| host_addr | input | 23 | Byte address |
| host_size | input | 2 | Transfer size code |
| host_wdata | input | 32 | Write data from host |
| host_rdata | output | 32 | Aligned read data to host |
| host_wait_n | output | 1 | Hold the host while low |
| seq_rd_req | output | 1 | Read request to sequencer |
| seq_wr_req | output | 1 | Write request to sequencer |
| seq_cfg_req | output | 1 | Mode-register request to sequencer |
| seq_bank | output | 2 | Bank select |
| seq_row | output | 11 | Row address |
| seq_col | output | 8 | Column address |
| seq_lane_mask | output | 4 | Per-lane block mask, high masks |
| seq_wdata | output | 32 | Lane-aligned write data |
| seq_cfg_word | output | 11 | Mode-register word |
| seq_rd_ack | input | 1 | Read acknowledge pulse |
| seq_wr_ack | input | 1 | Write acknowledge pulse |
| seq_cfg_ack | input | 1 | Mode-register acknowledge pulse |
| seq_rdata | input | 32 | Raw read data from sequencer |
| seq_refresh | input | 1 | Refresh in progress |

## Verification
The assertions rely on two host promises: select, strobes, address, size and data stay fixed while wait is low, and strobes are released in the completion cycle. They also rely on two sequencer promises: an acknowledge pulses for one cycle only while its own request is high, and refresh is never raised during an open transfer. The bench keeps to these rules. Its host task drives every input on the falling edge and changes them only after it has seen wait high. Its sequencer model raises refresh only before an access has been accepted.

// File: rtl/sha_pkg.sv
package sha_pkg;
    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_SPARE = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_WR_WAIT  = 3'd2,
        ST_CFG_WAIT = 3'd3,
        ST_DONE     = 3'd4
    } ctrl_state_e;
endpackage

// File: rtl/sha_lanes.sv
module sha_lanes #(
    parameter int LANES     = 4,
    parameter bit ALIGN_LOW = 1'b1,
    localparam int SEL_W    = $clog2(LANES),
    localparam int DW       = LANES * 8
) (
    input  logic [1:0]       size,
    input  logic [SEL_W-1:0] lane,
    input  logic [DW-1:0]    wdata_in,
    input  logic [DW-1:0]    rdata_raw,
    output logic [LANES-1:0] mask,
    output logic [DW-1:0]    wdata_out,
    output logic [DW-1:0]    rdata_aligned
);
    import sha_pkg::*;

    logic is_byte, is_half, is_word;
    logic [7:0] rbyte [LANES];
    logic [SEL_W-1:0] half_base;

    assign is_byte   = (size == SZ_BYTE);
    assign is_half   = (size == SZ_HALF);
    assign is_word   = !is_byte && !is_half;
    assign half_base = {lane[SEL_W-1:1], 1'b0};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic open_lane;
        assign rbyte[i]   = rdata_raw[8*i +: 8];
        assign open_lane  = is_word
                          || (is_byte && lane == SEL_W'(i))
                          || (is_half && lane[SEL_W-1:1] == (SEL_W-1)'(i / 2));
        assign mask[i]    = !open_lane;

        if (ALIGN_LOW) begin : g_align
            assign wdata_out[8*i +: 8] = is_byte ? wdata_in[7:0] :
                                         is_half ? wdata_in[8*(i%2) +: 8] :
                                                   wdata_in[8*i +: 8];
            if (i == 0) begin : g_l0
                assign rdata_aligned[7:0] = is_byte ? rbyte[lane] :
                                            is_half ? rbyte[half_base] :
                                                      rbyte[0];
            end else if (i == 1) begin : g_l1
                assign rdata_aligned[15:8] = is_half ? rbyte[half_base + SEL_W'(1)] :
                                             is_word ? rbyte[1] : 8'h00;
            end else begin : g_lhi
                assign rdata_aligned[8*i +: 8] = is_word ? rbyte[i] : 8'h00;
            end
        end else begin : g_raw
            assign wdata_out[8*i +: 8]     = wdata_in[8*i +: 8];
            assign rdata_aligned[8*i +: 8] = rbyte[i];
        end
    end
endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic go_rd,
    input  logic go_wr,
    input  logic go_cfg,
    input  logic rd_ack,
    input  logic wr_ack,
    input  logic cfg_ack,
    output logic rd_req,
    output logic wr_req,
    output logic cfg_req,
    output logic in_idle,
    output logic in_done,
    output logic capture
);
    import sha_pkg::*;

    ctrl_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        rd_req   = 1'b0;
        wr_req   = 1'b0;
        cfg_req  = 1'b0;
        in_idle  = 1'b0;
        in_done  = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_idle = 1'b1;
                if (go_cfg)     state_nx = ST_CFG_WAIT;
                else if (go_wr) state_nx = ST_WR_WAIT;
                else if (go_rd) state_nx = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    capture  = 1'b1;
                    state_nx = ST_DONE;
                end
            end
            ST_WR_WAIT: begin
                wr_req = 1'b1;
                if (wr_ack) state_nx = ST_DONE;
            end
            ST_CFG_WAIT: begin
                cfg_req = 1'b1;
                if (cfg_ack) state_nx = ST_DONE;
            end
            ST_DONE: begin
                in_done  = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sdram_host_adapter.sv
module sdram_host_adapter #(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 11,
    parameter int BANK_W    = 2,
    parameter int CFG_W     = 11,
    parameter bit ALIGN_LOW = 1'b1,
    localparam int LANES    = DATA_W / 8,
    localparam int SEL_W    = $clog2(LANES),
    localparam int COL_W    = ADDR_W - ROW_W - BANK_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_modeset_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_wait_n,
    output logic              seq_rd_req,
    output logic              seq_wr_req,
    output logic              seq_cfg_req,
    output logic [BANK_W-1:0] seq_bank,
    output logic [ROW_W-1:0]  seq_row,
    output logic [COL_W-1:0]  seq_col,
    output logic [LANES-1:0]  seq_lane_mask,
    output logic [DATA_W-1:0] seq_wdata,
    output logic [CFG_W-1:0]  seq_cfg_word,
    input  logic              seq_rd_ack,
    input  logic              seq_wr_ack,
    input  logic              seq_cfg_ack,
    input  logic [DATA_W-1:0] seq_rdata,
    input  logic              seq_refresh
);
    logic access, start_ok, is_write;
    logic go_rd, go_wr, go_cfg;
    logic in_idle, in_done, capture;
    logic [DATA_W-1:0] rd_aligned, rd_hold;

    assign access   = !host_sel_n && (!host_rd_n || !host_wr_n);
    assign start_ok = access && !seq_refresh;
    assign is_write = !host_wr_n;
    assign go_cfg   = start_ok && is_write && !host_modeset_n;
    assign go_wr    = start_ok && is_write && host_modeset_n;
    assign go_rd    = start_ok && !is_write;

    assign seq_bank     = host_addr[ADDR_W-1 -: BANK_W];
    assign seq_row      = host_addr[SEL_W+COL_W +: ROW_W];
    assign seq_col      = host_addr[SEL_W +: COL_W];
    assign seq_cfg_word = host_wdata[CFG_W-1:0];

    sha_lanes #(.LANES(LANES), .ALIGN_LOW(ALIGN_LOW)) u_lanes (
        .size          (host_size),
        .lane          (host_addr[SEL_W-1:0]),
        .wdata_in      (host_wdata),
        .rdata_raw     (seq_rdata),
        .mask          (seq_lane_mask),
        .wdata_out     (seq_wdata),
        .rdata_aligned (rd_aligned)
    );

    sha_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_rd   (go_rd),
        .go_wr   (go_wr),
        .go_cfg  (go_cfg),
        .rd_ack  (seq_rd_ack),
        .wr_ack  (seq_wr_ack),
        .cfg_ack (seq_cfg_ack),
        .rd_req  (seq_rd_req),
        .wr_req  (seq_wr_req),
        .cfg_req (seq_cfg_req),
        .in_idle (in_idle),
        .in_done (in_done),
        .capture (capture)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_hold <= '0;
        else if (capture) rd_hold <= rd_aligned;
    end

    assign host_rdata  = rd_hold;
    assign host_wait_n = in_done ||
                         !((in_idle && access) || seq_refresh ||
                           seq_rd_req || seq_wr_req || seq_cfg_req);
endmodule

// File: rtl/sha_checker.sv
module sha_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_sel_n,
    input logic [1:0]       host_size,
    input logic [31:0]      host_rdata,
    input logic             host_wait_n,
    input logic             seq_rd_req,
    input logic             seq_wr_req,
    input logic             seq_cfg_req,
    input logic [LANES-1:0] seq_lane_mask,
    input logic             seq_rd_ack,
    input logic             seq_wr_ack,
    input logic             seq_cfg_ack,
    input logic             seq_refresh
);
    logic any_req, acked;
    assign any_req = seq_rd_req || seq_wr_req || seq_cfg_req;
    assign acked   = (seq_rd_req && seq_rd_ack) || (seq_wr_req && seq_wr_ack) ||
                     (seq_cfg_req && seq_cfg_ack);

    a_r6_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_rd_req, seq_wr_req, seq_cfg_req}));

    a_r5_wait_during_request: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> !host_wait_n);

    a_r5_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        acked |=> (host_wait_n && !any_req));

    a_r6_read_held_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_rd_req) |-> $past(seq_rd_ack));

    a_r6_write_held_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_wr_req) |-> $past(seq_wr_ack));

    a_r2_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sel_n && host_size == 2'd1) |-> ($countones(seq_lane_mask) == LANES - 1));

    a_r9_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel_n && !seq_refresh && !any_req) |-> host_wait_n);

    a_r4_rdata_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_rd_req && seq_rd_ack) |=> $stable(host_rdata));
endmodule

bind sdram_host_adapter sha_checker #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_sel_n    (host_sel_n),
    .host_size     (host_size),
    .host_rdata    (host_rdata),
    .host_wait_n   (host_wait_n),
    .seq_rd_req    (seq_rd_req),
    .seq_wr_req    (seq_wr_req),
    .seq_cfg_req   (seq_cfg_req),
    .seq_lane_mask (seq_lane_mask),
    .seq_rd_ack    (seq_rd_ack),
    .seq_wr_ack    (seq_wr_ack),
    .seq_cfg_ack   (seq_cfg_ack),
    .seq_refresh   (seq_refresh)
);

// File: tb/sim_sdram_host_adapter.sv
module sim_sdram_host_adapter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_modeset_n = 1'b1;
    logic [22:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait_n;
    logic        seq_rd_req, seq_wr_req, seq_cfg_req;
    logic [1:0]  seq_bank;
    logic [10:0] seq_row;
    logic [7:0]  seq_col;
    logic [3:0]  seq_lane_mask;
    logic [31:0] seq_wdata;
    logic [10:0] seq_cfg_word;
    logic        seq_rd_ack = 1'b0, seq_wr_ack = 1'b0, seq_cfg_ack = 1'b0;
    logic [31:0] seq_rdata = '0;
    logic        seq_refresh = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdram_host_adapter u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [1:0] ln);
        case (sz)
            2'd1: exp_mask = ~(4'b0001 << ln);
            2'd2: exp_mask = ln[1] ? 4'b0011 : 4'b1100;
            default: exp_mask = 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd1: exp_wdata = {4{d[7:0]}};
            2'd2: exp_wdata = {2{d[15:0]}};
            default: exp_wdata = d;
        endcase
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [1:0] sz, input logic [1:0] ln, input logic [31:0] r);
        case (sz)
            2'd1: exp_rdata = {24'h0, r[8*ln +: 8]};
            2'd2: exp_rdata = {16'h0, r[16*ln[1] +: 16]};
            default: exp_rdata = r;
        endcase
    endfunction

    // kind: 0 read, 1 write, 2 mode-set write, 3 both strobes low
    task automatic xfer(input int kind, input logic [22:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input int delay, input int refr);
        logic [31:0] raw;
        raw = $urandom;
        if (refr > 0) seq_refresh = 1'b1;
        host_sel_n = 1'b0;
        host_addr = a; host_size = sz; host_wdata = d;
        host_rd_n = !(kind == 0 || kind == 3);
        host_wr_n = !(kind != 0);
        host_modeset_n = !(kind == 2);
        #1;
        chk(host_wait_n == 1'b0, "R5 wait low on presentation", 32'(host_wait_n), 32'd0);
        for (int k = 0; k < refr; k++) begin
            @(negedge clk);
            chk(!seq_rd_req && !seq_wr_req && !seq_cfg_req && !host_wait_n,
                "R8 held off by refresh", {seq_rd_req, seq_wr_req, seq_cfg_req, host_wait_n}, 32'd0);
        end
        seq_refresh = 1'b0;
        @(negedge clk);
        chk(seq_bank == a[22:21] && seq_row == a[20:10] && seq_col == a[9:2],
            "R1 address split", {seq_bank, seq_row, seq_col}, {a[22:21], a[20:10], a[9:2]});
        chk(seq_lane_mask == exp_mask(sz, a[1:0]), "R2 lane mask", 32'(seq_lane_mask), 32'(exp_mask(sz, a[1:0])));
        if (kind == 0)
            chk(seq_rd_req && !seq_wr_req && !seq_cfg_req, "R6 read request",
                {seq_rd_req, seq_wr_req, seq_cfg_req}, 32'b100);
        else if (kind == 2)
            chk(seq_cfg_req && !seq_wr_req && !seq_rd_req && seq_cfg_word == d[10:0],
                "R7 mode-set request", {seq_cfg_req, seq_wr_req, 9'h0, seq_cfg_word}, {2'b10, 9'h0, d[10:0]});
        else begin
            chk(seq_wr_req && !seq_rd_req && !seq_cfg_req, kind == 3 ? "R11 both strobes write" : "R6 write request",
                {seq_rd_req, seq_wr_req, seq_cfg_req}, 32'b010);
            chk(seq_wdata == exp_wdata(sz, d), "R3 write alignment", seq_wdata, exp_wdata(sz, d));
        end
        for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            chk(!host_wait_n && (seq_rd_req || seq_wr_req || seq_cfg_req), "R5 wait held until ack",
                32'(host_wait_n), 32'd0);
        end
        seq_rdata = raw;
        if (kind == 0) seq_rd_ack = 1'b1;
        else if (kind == 2) seq_cfg_ack = 1'b1;
        else seq_wr_ack = 1'b1;
        @(negedge clk);
        seq_rd_ack = 1'b0; seq_wr_ack = 1'b0; seq_cfg_ack = 1'b0;
        chk(host_wait_n && !seq_rd_req && !seq_wr_req && !seq_cfg_req, "R5 release after ack",
            32'(host_wait_n), 32'd1);
        if (kind == 0)
            chk(host_rdata == exp_rdata(sz, a[1:0], raw), "R4 read alignment", host_rdata, exp_rdata(sz, a[1:0], raw));
        host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_modeset_n = 1'b1;
        seq_rdata = $urandom;
        @(negedge clk);
        chk(host_wait_n, "R5 idle after completion", 32'(host_wait_n), 32'd1);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] last;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!seq_rd_req && !seq_wr_req && !seq_cfg_req && host_wait_n && host_rdata == 0,
            "R10 reset state", host_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 4; s++)
            for (int l = 0; l < 4; l++) begin
                xfer(0, {21'h1ABCDE & 21'h1FFFFF, 2'(l)}, 2'(s), 32'h0, l % 3, 0);
                xfer(1, {21'h0F0F0F, 2'(l)}, 2'(s), $urandom, 1, 0);
            end
        xfer(2, 23'h12345, 2'd0, 32'hFFFF_F5A3, 2, 0);
        xfer(3, 23'h7FFFFF, 2'd2, 32'hCAFE_BEEF, 0, 0);
        xfer(0, 23'h400002, 2'd1, 32'h0, 1, 3);
        // R9: strobes with select high are ignored, read data untouched
        last = host_rdata;
        host_sel_n = 1'b1; host_rd_n = 1'b0; host_wr_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(host_wait_n && !seq_rd_req && !seq_wr_req && !seq_cfg_req && host_rdata == last,
                "R9 deselected strobes ignored", {seq_rd_req, seq_wr_req, seq_cfg_req, host_wait_n}, 32'd1);
        end
        host_rd_n = 1'b1; host_wr_n = 1'b1;
        // R8: refresh alone in idle lowers wait
        seq_refresh = 1'b1;
        @(negedge clk);
        chk(!host_wait_n && !seq_rd_req && !seq_wr_req, "R8 refresh lowers wait", 32'(host_wait_n), 32'd0);
        seq_refresh = 1'b0;
        @(negedge clk);
        for (int t = 0; t < 300; t++)
            xfer(int'($urandom_range(0, 3)), 23'($urandom), 2'($urandom), $urandom,
                 int'($urandom_range(0, 4)), ($urandom_range(0, 7) == 0) ? 2 : 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule